// File: doc/BRIEF.md
# Type-1 Configuration Port Decoder

This block sits on a narrow host I/O port bus and converts port accesses into configuration-space transactions. A 32-bit address register, reached at one port, selects the target bus, the device/function number and a register inside a 4096-byte configuration space per function. A four-byte data window, reached at the next four ports, then starts a configuration read or write for that register.

For every window access the block derives the byte enables from the port offset and the access size. It moves host write data onto the addressed byte lanes, and it moves returned read data down so that the addressed lanes start at bit 0. The downstream configuration target answers each request through a request/acknowledge handshake and can report that no device responded. Host software must write the address register before each configuration access. When the enable bit of that register is clear, the data window issues nothing and reads back all ones.

The block also decodes a byte write to the top byte of the address register port. It keeps that byte's low bit as a separate mechanism-select output and leaves the address register alone.

Top module: `cfg1_port_bridge`

## Requirements
- R1: After reset the address register reads 0, `mode_sel` is 0, and neither `host_ack` nor `cfg_req` is asserted.
- R2: A 32-bit write (size code 2) to port 0x0CF8 stores all 32 bits. A 32-bit read of 0x0CF8 returns exactly the last value written, including 0x80000000.
- R3: Only a 32-bit access at offset 0 changes the address register. A byte write (size code 0) to port 0x0CFB sets `mode_sel` to write-data bit 0 and leaves the register unchanged. Any read of 0x0CF8 to 0x0CFB other than a 32-bit read at 0x0CF8 returns 0xFFFFFFFF.
- R4: A window request carries the following fields from the address register: bus from bits 23:16, device/function from bits 15:8, and the dword index as `cfg_reg`. `cfg_reg` is the concatenation of register bits 27:24 (upper four) and bits 7:2 (lower six).
- R5: Byte enables depend on the size code and the window offset (host address bits 1:0):
  - size 0: a single lane at the offset;
  - size 1: lanes 1:0 or 3:2, chosen by offset bit 1;
  - size 2: all four lanes.
- R6: Host write data is right-aligned. It is shifted left onto the enabled lanes, by 8 bits per lane.
- R7: Read data is shifted right so that the lowest enabled lane lands at bit 0. Bits above the access width return 0.
- R8: While address bit 31 is clear, a window access raises no `cfg_req`, acknowledges one cycle after the strobe and, for a read, returns 0xFFFFFFFF.
- R9: When the target acknowledges with `cfg_nodev` high, a window read returns 0xFFFFFFFF.
- R10: Timing and handshake rules:
  - address-port accesses acknowledge one cycle after the strobe;
  - a window access raises `cfg_req` one cycle after the strobe, and the request stays stable until `cfg_ack` is sampled;
  - `host_ack` is a one-cycle pulse in the cycle after that handshake;
  - strobes that arrive while a request is outstanding are ignored.
- R11: Strobes to ports outside 0x0CF8 to 0x0CFF get no acknowledge and have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_addr | input | 16 | Host port address |
| host_size | input | 2 | Access size: 0 byte, 1 half, 2 word (3 treated as word) |
| host_wdata | input | 32 | Right-aligned host write data |
| host_rd | input | 1 | Read strobe, one cycle |
| host_wr | input | 1 | Write strobe, one cycle |
| host_rdata | output | 32 | Read data, valid with host_ack |
| host_ack | output | 1 | One-cycle completion pulse |
| mode_sel | output | 1 | Mechanism-select bit |
| cfg_req | output | 1 | Configuration request, held until acknowledged |
| cfg_we | output | 1 | Request is a write |
| cfg_bus | output | 8 | Target bus number |
| cfg_devfn | output | 8 | Target device/function |
| cfg_reg | output | 10 | Dword index in the 4096-byte space |
| cfg_be | output | 4 | Byte enables |
| cfg_wdata | output | 32 | Lane-aligned write data |
| cfg_ack | input | 1 | Target acknowledge |
| cfg_rdata | input | 32 | Target read dword |
| cfg_nodev | input | 1 | Target reports no device, valid with cfg_ack |

## Verification
The cycle in which each result is due depends on the kind of access:
- Address-port and disabled-window accesses are acknowledged in the cycle right after the strobe edge.
- An enabled window access shows `cfg_req` in that same cycle. Its `host_ack` arrives two cycles plus the target's programmed delay after the strobe.

The bench drives the strobe on a falling edge and counts those edges to the due cycle. On each falling edge it compares the outputs against its own byte-level model of the address register and configuration memory, including the intermediate cycles where the request must still be pending and the acknowledge absent. An address-register write injected while a request is outstanding is read back afterwards to show it was ignored.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  typedef enum logic [1:0] {
    PK_NONE = 2'd0,
    PK_ADDR = 2'd1,
    PK_DATA = 2'd2
  } port_kind_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } br_state_e;
endpackage

// File: rtl/cfgp_port_decode.sv
module cfgp_port_decode
  import cfgp_pkg::*;
#(
  parameter int               AW   = 16,
  parameter logic [AW-1:0]    BASE = 16'h0CF8
) (
  input  logic [AW-1:0] host_addr,
  output port_kind_e    kind,
  output logic [1:0]    offset
);
  localparam logic [AW-1:0] BLOCK_MASK = ~(AW'(7));

  always_comb begin
    offset = host_addr[1:0];
    kind   = PK_NONE;
    if ((host_addr & BLOCK_MASK) == (BASE & BLOCK_MASK)) begin
      kind = host_addr[2] ? PK_DATA : PK_ADDR;
    end
  end
endmodule

// File: rtl/cfgp_addr_reg.sv
module cfgp_addr_reg #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_addr,
  input  logic          load_mode,
  input  logic [DW-1:0] wdata,
  input  logic          mode_bit,
  output logic [DW-1:0] addr_q,
  output logic          mode_q
);
  logic [DW-1:0] addr_d;
  logic          mode_d;

  always_comb begin
    addr_d = load_addr ? wdata : addr_q;
    mode_d = load_mode ? mode_bit : mode_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      mode_q <= 1'b0;
    end else begin
      if (load_addr) addr_q <= addr_d;
      if (load_mode) mode_q <= mode_d;
    end
  end
endmodule

// File: rtl/cfgp_lane_steer.sv
module cfgp_lane_steer
  import cfgp_pkg::*;
#(
  parameter int DW = 32,
  parameter int NB = DW / 8,
  parameter int OW = $clog2(NB)
) (
  input  acc_size_e     size,
  input  logic [OW-1:0] off,
  input  logic [DW-1:0] wdata_in,
  input  logic [DW-1:0] rdata_in,
  output logic [NB-1:0] be_out,
  output logic [DW-1:0] wdata_out,
  output logic [DW-1:0] rdata_out
);
  logic [OW-1:0] shift;
  logic [OW:0]   nbytes;
  logic [NB-1:0] span;
  logic [DW-1:0] aligned;

  always_comb begin
    case (size)
      SZ_BYTE: begin
        shift  = off;
        nbytes = (OW+1)'(1);
      end
      SZ_HALF: begin
        shift  = {off[OW-1:1], 1'b0};
        nbytes = (OW+1)'(2);
      end
      default: begin
        shift  = '0;
        nbytes = (OW+1)'(NB);
      end
    endcase
  end

  for (genvar i = 0; i < NB; i++) begin : g_lane
    assign span[i]              = ((OW+1)'(i) < nbytes);
    assign rdata_out[8*i +: 8]  = span[i] ? aligned[8*i +: 8] : 8'h00;
  end

  assign be_out    = span << shift;
  assign wdata_out = wdata_in << {shift, 3'b000};
  assign aligned   = rdata_in >> {shift, 3'b000};
endmodule

// File: rtl/cfg1_port_bridge.sv
module cfg1_port_bridge
  import cfgp_pkg::*;
#(
  parameter int                 HOST_AW   = 16,
  parameter int                 DW        = 32,
  parameter logic [HOST_AW-1:0] PORT_BASE = 16'h0CF8,
  parameter int                 BUS_W     = 8,
  parameter int                 FN_W      = 8,
  parameter int                 EXT_W     = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [HOST_AW-1:0]     host_addr,
  input  logic [1:0]             host_size,
  input  logic [DW-1:0]          host_wdata,
  input  logic                   host_rd,
  input  logic                   host_wr,
  output logic [DW-1:0]          host_rdata,
  output logic                   host_ack,
  output logic                   mode_sel,
  output logic                   cfg_req,
  output logic                   cfg_we,
  output logic [BUS_W-1:0]       cfg_bus,
  output logic [FN_W-1:0]        cfg_devfn,
  output logic [EXT_W+5:0]       cfg_reg,
  output logic [DW/8-1:0]        cfg_be,
  output logic [DW-1:0]          cfg_wdata,
  input  logic                   cfg_ack,
  input  logic [DW-1:0]          cfg_rdata,
  input  logic                   cfg_nodev
);
  localparam int NB     = DW / 8;
  localparam int EN_BIT = DW - 1;
  localparam int IDX_LO = 2;
  localparam int IDX_W  = 6;
  localparam int FN_LO  = IDX_LO + IDX_W;
  localparam int BUS_LO = FN_LO + FN_W;
  localparam int EXT_LO = BUS_LO + BUS_W;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_l;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_l = rst_pipe[1];

  // decode
  port_kind_e kind;
  logic [1:0] off;
  acc_size_e  hsize;
  logic       is_word, strobe, addr_hit, data_hit, issue, en;
  logic       load_addr, load_mode;
  logic [DW-1:0] addr_q;
  br_state_e  state_q, state_d;

  cfgp_port_decode #(.AW(HOST_AW), .BASE(PORT_BASE)) u_decode (
    .host_addr (host_addr),
    .kind      (kind),
    .offset    (off)
  );

  always_comb begin
    hsize     = acc_size_e'(host_size);
    is_word   = (hsize == SZ_WORD) || (hsize == SZ_RSVD);
    strobe    = (host_rd | host_wr) && (state_q == ST_IDLE);
    addr_hit  = strobe && (kind == PK_ADDR);
    data_hit  = strobe && (kind == PK_DATA);
    en        = addr_q[EN_BIT];
    load_addr = addr_hit && host_wr && is_word && (off == 2'd0);
    load_mode = addr_hit && host_wr && (hsize == SZ_BYTE) && (off == 2'd3);
    issue     = data_hit && en;
  end

  cfgp_addr_reg #(.DW(DW)) u_addr (
    .clk       (clk),
    .rst_n     (rst_l),
    .load_addr (load_addr),
    .load_mode (load_mode),
    .wdata     (host_wdata),
    .mode_bit  (host_wdata[0]),
    .addr_q    (addr_q),
    .mode_q    (mode_sel)
  );

  // request state
  logic          req_we_q;
  acc_size_e     req_size_q;
  logic [1:0]    req_off_q;
  logic [DW-1:0] req_wdata_q;
  logic [DW-1:0] rdata_aligned;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (issue)   state_d = ST_WAIT;
      ST_WAIT: if (cfg_ack) state_d = ST_IDLE;
      default:              state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) begin
      state_q     <= ST_IDLE;
      req_we_q    <= 1'b0;
      req_size_q  <= SZ_BYTE;
      req_off_q   <= '0;
      req_wdata_q <= '0;
    end else begin
      state_q <= state_d;
      if (issue) begin
        req_we_q    <= host_wr;
        req_size_q  <= hsize;
        req_off_q   <= off;
        req_wdata_q <= host_wdata;
      end
    end
  end

  cfgp_lane_steer #(.DW(DW)) u_steer (
    .size      (req_size_q),
    .off       (req_off_q),
    .wdata_in  (req_wdata_q),
    .rdata_in  (cfg_rdata),
    .be_out    (cfg_be),
    .wdata_out (cfg_wdata),
    .rdata_out (rdata_aligned)
  );

  assign cfg_req   = (state_q == ST_WAIT);
  assign cfg_we    = req_we_q;
  assign cfg_bus   = addr_q[BUS_LO +: BUS_W];
  assign cfg_devfn = addr_q[FN_LO +: FN_W];
  assign cfg_reg   = {addr_q[EXT_LO +: EXT_W], addr_q[IDX_LO +: IDX_W]};

  // host response
  logic          ack_d;
  logic [DW-1:0] rdata_d;

  always_comb begin
    ack_d = addr_hit || (data_hit && !en) || (cfg_req && cfg_ack);
    if (cfg_req) begin
      rdata_d = (cfg_nodev || req_we_q) ? '1 : rdata_aligned;
    end else if (addr_hit && host_rd && is_word && (off == 2'd0)) begin
      rdata_d = addr_q;
    end else begin
      rdata_d = '1;
    end
  end

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) begin
      host_ack   <= 1'b0;
      host_rdata <= '1;
    end else begin
      host_ack <= ack_d;
      if (ack_d) host_rdata <= rdata_d;
    end
  end

  // checks
  a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_l)
    (cfg_req && !cfg_ack) |=> (cfg_req && $stable(cfg_be) && $stable(cfg_wdata)
                               && $stable(cfg_reg) && $stable(cfg_we)));

  a_r8_req_needs_enable: assert property (@(posedge clk) disable iff (!rst_l)
    $rose(cfg_req) |-> ($past(host_rd || host_wr) && addr_q[EN_BIT]));

  a_r10_ack_after_handshake: assert property (@(posedge clk) disable iff (!rst_l)
    (cfg_req && cfg_ack) |=> (host_ack && !cfg_req));

  a_r3_addr_hold: assert property (@(posedge clk) disable iff (!rst_l)
    !(host_wr && (host_addr == PORT_BASE) && host_size[1]) |=> $stable(addr_q));

  a_r5_byte_single_lane: assert property (@(posedge clk) disable iff (!rst_l)
    (cfg_req && (req_size_q == SZ_BYTE)) |-> ($countones(cfg_be) == 1));

  a_r9_nodev_ones: assert property (@(posedge clk) disable iff (!rst_l)
    (cfg_req && cfg_ack && cfg_nodev && !cfg_we) |=> (host_rdata == '1));
endmodule

// File: tb/cfg1_port_bridge_tb_top.sv
module cfg1_port_bridge_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic [15:0] host_addr = '0;
  logic [1:0]  host_size = '0;
  logic [31:0] host_wdata = '0;
  logic        host_rd = 1'b0;
  logic        host_wr = 1'b0;
  logic [31:0] host_rdata;
  logic        host_ack, mode_sel, cfg_req, cfg_we;
  logic [7:0]  cfg_bus, cfg_devfn;
  logic [9:0]  cfg_reg;
  logic [3:0]  cfg_be;
  logic [31:0] cfg_wdata;
  logic        cfg_ack = 1'b0;
  logic [31:0] cfg_rdata = '0;
  logic        cfg_nodev = 1'b0;

  always #10 clk = ~clk;

  cfg1_port_bridge dut_i (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_size(host_size),
    .host_wdata(host_wdata), .host_rd(host_rd), .host_wr(host_wr),
    .host_rdata(host_rdata), .host_ack(host_ack), .mode_sel(mode_sel),
    .cfg_req(cfg_req), .cfg_we(cfg_we), .cfg_bus(cfg_bus), .cfg_devfn(cfg_devfn),
    .cfg_reg(cfg_reg), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
    .cfg_ack(cfg_ack), .cfg_rdata(cfg_rdata), .cfg_nodev(cfg_nodev)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] init_byte(input int key);
    return key[7:0] ^ key[15:8] ^ 8'h3C;
  endfunction

  // target model: byte-addressed store, programmable acknowledge delay
  int tgt_delay = 0;
  int tgt_cnt = 0;
  logic [7:0] tgt_mem [int];

  always @(negedge clk) begin
    if (cfg_ack) begin
      cfg_ack = 1'b0;
    end else if (cfg_req) begin
      if (tgt_cnt >= tgt_delay) begin
        tgt_cnt   = 0;
        cfg_ack   = 1'b1;
        cfg_nodev = (cfg_devfn == 8'hF8);
        for (int b = 0; b < 4; b++) begin
          int key;
          key = int'({cfg_bus, cfg_devfn, cfg_reg, 2'(b)});
          if (!cfg_nodev && cfg_we && cfg_be[b]) tgt_mem[key] = cfg_wdata[8*b +: 8];
          cfg_rdata[8*b +: 8] = tgt_mem.exists(key) ? tgt_mem[key] : init_byte(key);
        end
      end else begin
        tgt_cnt++;
      end
    end
  end

  // reference model of host-visible state
  logic [31:0] ref_addr = '0;
  bit          ref_mode = 0;
  logic [7:0]  ref_mem [int];

  task automatic acc(input logic [15:0] a, input logic [1:0] sz, input logic [31:0] wd,
                     input bit rd, input int dly, input bit inject, input string tag);
    @(negedge clk);
    tgt_delay = dly;
    host_addr = a; host_size = sz; host_wdata = wd; host_rd = rd; host_wr = !rd;
    @(negedge clk);
    host_rd = 1'b0; host_wr = 1'b0;
    if (a[15:3] != 13'h019F) begin
      chk(!host_ack && !cfg_req, {"R11 no ack ", tag}, {30'd0, host_ack, cfg_req}, 32'd0);
      @(negedge clk);
      chk(!host_ack && !cfg_req, {"R11 still idle ", tag}, {30'd0, host_ack, cfg_req}, 32'd0);
    end else if (!a[2]) begin
      chk(host_ack && !cfg_req, {"R10 reg ack ", tag}, {30'd0, host_ack, cfg_req}, 32'd2);
      if (rd) begin
        logic [31:0] exp;
        exp = (sz == 2'd2 && a[1:0] == 2'd0) ? ref_addr : 32'hFFFF_FFFF;
        chk(host_rdata == exp, {"R2/R3 reg read ", tag}, host_rdata, exp);
      end else begin
        if (sz == 2'd2 && a[1:0] == 2'd0) ref_addr = wd;
        if (sz == 2'd0 && a[1:0] == 2'd3) ref_mode = wd[0];
      end
      chk(mode_sel == ref_mode, {"R3 mode bit ", tag}, {31'd0, mode_sel}, {31'd0, ref_mode});
    end else if (!ref_addr[31]) begin
      chk(host_ack && !cfg_req, {"R8 disabled ack ", tag}, {30'd0, host_ack, cfg_req}, 32'd2);
      if (rd) chk(host_rdata == 32'hFFFF_FFFF, {"R8 disabled read ", tag}, host_rdata, 32'hFFFF_FFFF);
    end else begin
      int n, start, base;
      logic [3:0]  be;
      logic [9:0]  regw;
      logic [31:0] exp;
      bit nodev;
      n     = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
      start = (sz == 2'd0) ? int'(a[1:0]) : (sz == 2'd1) ? int'({a[1], 1'b0}) : 0;
      be = '0;
      for (int i = 0; i < n; i++) be[start+i] = 1'b1;
      regw  = {ref_addr[27:24], ref_addr[7:2]};
      nodev = (ref_addr[15:8] == 8'hF8);
      chk(cfg_req && !host_ack, {"R10 req raised ", tag}, {30'd0, cfg_req, host_ack}, 32'd2);
      chk(cfg_bus == ref_addr[23:16], {"R4 bus ", tag}, {24'd0, cfg_bus}, {24'd0, ref_addr[23:16]});
      chk(cfg_devfn == ref_addr[15:8], {"R4 devfn ", tag}, {24'd0, cfg_devfn}, {24'd0, ref_addr[15:8]});
      chk(cfg_reg == regw, {"R4 reg index ", tag}, {22'd0, cfg_reg}, {22'd0, regw});
      chk(cfg_be == be, {"R5 byte enables ", tag}, {28'd0, cfg_be}, {28'd0, be});
      chk(cfg_we == !rd, {"R4 direction ", tag}, {31'd0, cfg_we}, {31'd0, !rd});
      if (!rd) begin
        for (int i = 0; i < n; i++)
          chk(cfg_wdata[8*(start+i) +: 8] == wd[8*i +: 8], {"R6 write lane ", tag},
              {24'd0, cfg_wdata[8*(start+i) +: 8]}, {24'd0, wd[8*i +: 8]});
      end
      if (inject) begin
        host_addr = 16'h0CF8; host_size = 2'd2; host_wdata = 32'h0; host_wr = 1'b1;
      end
      for (int k = 0; k < dly; k++) begin
        @(negedge clk);
        if (k == 0) host_wr = 1'b0;
        chk(cfg_req && !host_ack, {"R10 req held ", tag}, {30'd0, cfg_req, host_ack}, 32'd2);
      end
      @(negedge clk);
      host_wr = 1'b0;
      chk(host_ack && !cfg_req, {"R10 done ", tag}, {30'd0, host_ack, cfg_req}, 32'd2);
      base = int'({ref_addr[23:16], ref_addr[15:8], regw, 2'b00});
      exp = '0;
      for (int i = 0; i < n; i++) begin
        int k2;
        k2 = base + start + i;
        if (rd) exp[8*i +: 8] = ref_mem.exists(k2) ? ref_mem[k2] : init_byte(k2);
        else if (!nodev) ref_mem[k2] = wd[8*i +: 8];
      end
      if (rd) begin
        if (nodev) exp = 32'hFFFF_FFFF;
        chk(host_rdata == exp, {nodev ? "R9 no device " : "R7 read data ", tag}, host_rdata, exp);
      end
    end
    @(negedge clk);
    chk(!host_ack, {"R10 single pulse ", tag}, {31'd0, host_ack}, 32'd0);
  endtask

  initial begin
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(!host_ack && !cfg_req && !mode_sel, "R1 reset outputs",
        {29'd0, host_ack, cfg_req, mode_sel}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!host_ack && !cfg_req && !mode_sel, "R1 after release",
        {29'd0, host_ack, cfg_req, mode_sel}, 32'd0);
    acc(16'h0CF8, 2'd2, 0, 1, 0, 0, "R1 addr reset value");
    acc(16'h0CFC, 2'd2, 0, 1, 0, 0, "R8 read");
    acc(16'h0CFE, 2'd1, 32'h1234, 0, 0, 0, "R8 write");
    acc(16'h0CF8, 2'd2, 32'h8000_0000, 0, 0, 0, "R2 write enable");
    acc(16'h0CF8, 2'd2, 0, 1, 0, 0, "R2 readback");
    acc(16'h0CFB, 2'd0, 32'h1, 0, 0, 0, "R3 mode set");
    acc(16'h0CF8, 2'd1, 32'h1234, 0, 0, 0, "R3 half write ignored");
    acc(16'h0CF8, 2'd2, 0, 1, 0, 0, "R3 addr unchanged");
    acc(16'h0CF9, 2'd0, 0, 1, 0, 0, "R3 byte read ones");
    acc(16'h0CF8, 2'd2, 32'h8312_2A44, 0, 0, 0, "R2 ext register");
    acc(16'h0CFC, 2'd2, 32'hDEAD_BEEF, 0, 1, 0, "R6 word write");
    acc(16'h0CFC, 2'd2, 0, 1, 0, 0, "R7 word read");
    for (int o = 0; o < 4; o++) acc(16'h0CFC + 16'(o), 2'd0, 32'h11 * (o + 1), 0, o, 0, "R5 byte write");
    for (int o = 0; o < 4; o++) acc(16'h0CFC + 16'(o), 2'd0, 0, 1, 3 - o, 0, "R7 byte read");
    acc(16'h0CFE, 2'd1, 32'hA5C3, 0, 2, 0, "R6 upper half write");
    acc(16'h0CFE, 2'd1, 0, 1, 1, 0, "R7 upper half read");
    acc(16'h0CFD, 2'd1, 0, 1, 0, 0, "R5 odd half read");
    acc(16'h0CFC, 2'd2, 0, 1, 0, 0, "R7 merged word");
    acc(16'h0CF8, 2'd2, 32'h8100_0810, 0, 0, 0, "R4 new target");
    acc(16'h0CFD, 2'd0, 0, 1, 1, 0, "R7 untouched byte");
    acc(16'h0CF8, 2'd2, 32'h8000_F804, 0, 0, 0, "R9 select absent");
    acc(16'h0CFC, 2'd2, 32'h1234_5678, 0, 0, 0, "R9 write absent");
    acc(16'h0CFC, 2'd2, 0, 1, 2, 0, "R9 read absent");
    acc(16'h0CF4, 2'd2, 32'h0, 0, 0, 0, "R11 below range");
    acc(16'h0080, 2'd2, 0, 1, 0, 0, "R11 far port");
    acc(16'h0CF8, 2'd2, 0, 1, 0, 0, "R11 addr unchanged");
    acc(16'h0CF8, 2'd2, 32'h8007_1020, 0, 0, 0, "R10 setup");
    acc(16'h0CFE, 2'd0, 0, 1, 2, 1, "R10 busy inject");
    acc(16'h0CF8, 2'd2, 0, 1, 0, 0, "R10 inject ignored");
    acc(16'h0CF8, 2'd2, 32'h0007_1020, 0, 0, 0, "R8 disable");
    acc(16'h0CFF, 2'd0, 0, 1, 0, 0, "R8 disabled byte");
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule